// File: doc/BRIEF.md
# Subtract and Compare Flag ALU

This block is the subtract-family slice of a 16-bit integer datapath. It takes a destination operand, a source operand, an operation code, a width select and the incoming carry flag. It computes one of six operations: subtract, subtract with borrow, compare, negate, increment or decrement. The operation runs at either byte or word width. One clock after a valid strobe, the block presents the registered result, a register write-enable and the six arithmetic status flags: carry, zero, sign, overflow, parity and auxiliary carry.

All six operations share a single adder. Subtraction is done by adding the inverted source with an inverted carry. The carry and auxiliary flags are inverted back to borrow meaning, except for increment. In byte mode only the low half of each operand takes part. The upper half of the result is forced to zero, and every flag is taken at the byte boundary. Compare behaves as subtract but never requests a write.

Top module: `sub_flag_alu`

## Requirements
- R1: A cycle with `in_valid` high produces, on the next rising edge, `out_valid` high together with the result and flags of that operation. A cycle with `in_valid` low produces `out_valid` and `wr_en` low on the next edge, and `result` and all six flags keep their values.
- R2: Code 0 (subtract) yields `result` = (dst - src) modulo 2^n and `wr_en` = 1. CF is set exactly when dst < src as unsigned n-bit values, where n is 8 or 16.
- R3: Code 1 (subtract with borrow) yields (dst - src - cf_in) modulo 2^n and `wr_en` = 1. CF is set exactly when dst < src + cf_in.
- R4: Code 2 (compare) sets all flags as code 0 does and presents the difference on `result`, but `wr_en` stays 0. Codes 6 and 7 behave exactly as code 2.
- R5: Code 4 (increment) yields dst + 1, and code 5 (decrement) yields dst - 1, both modulo 2^n with `wr_en` = 1. For both, CF equals `cf_in`, and the other five flags follow the result.
- R6: Code 3 (negate) yields (0 - dst) modulo 2^n with `wr_en` = 1. CF is 0 when dst is zero and 1 otherwise. Negating 80h in byte mode or 8000h in word mode returns the same value with OF = 1.
- R7: ZF is 1 exactly when the n-bit result is zero, and SF equals result bit n-1.
- R8: OF is 1 exactly when the operation overflows as signed n-bit arithmetic. For example, a word subtract of 7FFFh minus FFFFh gives 8000h with OF = 1.
- R9: PF is 1 when result bits 7..0 hold an even number of ones.
- R10: AF is 1 on a borrow out of bit 3. For increment it is 1 on a carry out of bit 3.
- R11: With `wide` = 0 (byte mode), operand bits 15..8 have no effect, `result` bits 15..8 are 0, and CF, SF and OF are taken at bit 7. With `wide` = 1 all 16 bits are used.
- R12: After reset, `out_valid`, `wr_en`, `result` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| op_code | input | 3 | Operation select (0 sub, 1 sbb, 2 cmp, 3 neg, 4 inc, 5 dec, 6/7 cmp) |
| wide | input | 1 | 1 = word, 0 = byte |
| dst_opnd | input | DATA_W | Destination operand |
| src_opnd | input | DATA_W | Source operand |
| cf_in | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result valid, one cycle after strobe |
| wr_en | output | 1 | Result write-back request |
| result | output | DATA_W | Registered result |
| cf | output | 1 | Carry / borrow flag |
| zf | output | 1 | Zero flag |
| sf | output | 1 | Sign flag |
| of | output | 1 | Signed overflow flag |
| pf | output | 1 | Parity flag on the low byte |
| af | output | 1 | Auxiliary carry, bit 3 |

## Verification
Byte-mode subtract is swept exhaustively, and subtract with borrow and compare are swept densely. Together these cover every borrow, half-borrow and signed-overflow combination. An adder that mixes up carry and borrow polarity, or that takes CF or OF at bit 15 in byte mode, therefore disagrees with the bench on roughly half the cases. Negate, increment and decrement are checked for every byte value with both carry inputs. Any CF leak into increment or decrement shows up directly, as do the special cases of negating zero and negating the most negative value. Word mode is checked on boundary values such as 7FFFh, 8000h and FFFFh. Dirty upper bytes in byte mode and the idle-hold behaviour confirm that ignored inputs cannot reach the outputs.

// File: rtl/sfa_pkg.sv
package sfa_pkg;

    typedef enum logic [2:0] {
        OP_SUB  = 3'd0,
        OP_SBB  = 3'd1,
        OP_CMP  = 3'd2,
        OP_NEG  = 3'd3,
        OP_INC  = 3'd4,
        OP_DEC  = 3'd5,
        OP_RSV6 = 3'd6,
        OP_RSV7 = 3'd7
    } sfa_op_e;

    typedef struct packed {
        logic cf;
        logic zf;
        logic sf;
        logic of;
        logic pf;
        logic af;
    } sfa_flags_t;

endpackage

// File: rtl/sfa_operand_sel.sv
module sfa_operand_sel
    import sfa_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  sfa_op_e           op,
    input  logic              wide,
    input  logic [DATA_W-1:0] dst,
    input  logic [DATA_W-1:0] src,
    input  logic              cf_in,
    output logic [DATA_W-1:0] add_a,
    output logic [DATA_W-1:0] add_b,
    output logic              add_cin,
    output logic              borrow_sense,
    output logic              keep_cf,
    output logic              write_req
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W-1:0] width_mask;
    logic [DATA_W-1:0] dst_m;
    logic [DATA_W-1:0] src_m;

    always_comb begin
        width_mask = wide ? {DATA_W{1'b1}} : {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};
        dst_m      = dst & width_mask;
        src_m      = src & width_mask;

        add_a        = dst_m;
        add_b        = ~src_m & width_mask;
        add_cin      = 1'b1;
        borrow_sense = 1'b1;
        keep_cf      = 1'b0;
        write_req    = 1'b1;

        unique case (op)
            OP_SUB: ;
            OP_SBB: add_cin = ~cf_in;
            OP_NEG: begin
                add_a = '0;
                add_b = ~dst_m & width_mask;
            end
            OP_INC: begin
                add_b        = '0;
                borrow_sense = 1'b0;
                keep_cf      = 1'b1;
            end
            OP_DEC: begin
                add_b   = ~{{(DATA_W-1){1'b0}}, 1'b1} & width_mask;
                keep_cf = 1'b1;
            end
            default: write_req = 1'b0;
        endcase
    end

endmodule

// File: rtl/sfa_adder_core.sv
module sfa_adder_core #(
    parameter int DATA_W = 16,
    parameter int NIB_W  = 4
) (
    input  logic [DATA_W-1:0] add_a,
    input  logic [DATA_W-1:0] add_b,
    input  logic              add_cin,
    output logic [DATA_W-1:0] sum,
    output logic              nib_co,
    output logic              half_c_msb,
    output logic              half_co,
    output logic              full_c_msb,
    output logic              full_co
);
    localparam int HALF_W = DATA_W / 2;

    logic [DATA_W:0] ext_sum;
    logic [DATA_W:0] carry_into;

    always_comb begin
        ext_sum    = {1'b0, add_a} + {1'b0, add_b} + {{DATA_W{1'b0}}, add_cin};
        carry_into = ext_sum ^ {1'b0, add_a} ^ {1'b0, add_b};
        sum        = ext_sum[DATA_W-1:0];
        nib_co     = carry_into[NIB_W];
        half_c_msb = carry_into[HALF_W-1];
        half_co    = carry_into[HALF_W];
        full_c_msb = carry_into[DATA_W-1];
        full_co    = carry_into[DATA_W];
    end

endmodule

// File: rtl/sfa_flag_gen.sv
module sfa_flag_gen
    import sfa_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int PAR_W  = 8
) (
    input  logic [DATA_W-1:0] sum,
    input  logic              wide,
    input  logic              nib_co,
    input  logic              half_c_msb,
    input  logic              half_co,
    input  logic              full_c_msb,
    input  logic              full_co,
    input  logic              borrow_sense,
    input  logic              keep_cf,
    input  logic              cf_in,
    output logic [DATA_W-1:0] res,
    output sfa_flags_t        flags
);
    localparam int HALF_W = DATA_W / 2;

    logic carry_out;
    logic carry_msb;

    always_comb begin
        res       = wide ? sum : {{(DATA_W-HALF_W){1'b0}}, sum[HALF_W-1:0]};
        carry_out = wide ? full_co    : half_co;
        carry_msb = wide ? full_c_msb : half_c_msb;

        flags.cf = keep_cf ? cf_in : (carry_out ^ borrow_sense);
        flags.zf = (res == '0);
        flags.sf = wide ? res[DATA_W-1] : res[HALF_W-1];
        flags.of = carry_out ^ carry_msb;
        flags.pf = ~^res[PAR_W-1:0];
        flags.af = nib_co ^ borrow_sense;
    end

endmodule

// File: rtl/sub_flag_alu.sv
module sub_flag_alu
    import sfa_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NIB_W  = 4,
    parameter int PAR_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        op_code,
    input  logic              wide,
    input  logic [DATA_W-1:0] dst_opnd,
    input  logic [DATA_W-1:0] src_opnd,
    input  logic              cf_in,
    output logic              out_valid,
    output logic              wr_en,
    output logic [DATA_W-1:0] result,
    output logic              cf,
    output logic              zf,
    output logic              sf,
    output logic              of,
    output logic              pf,
    output logic              af
);

    typedef struct packed {
        logic              vld;
        logic              wr;
        logic [DATA_W-1:0] res;
        sfa_flags_t        flg;
    } alu_state_t;

    alu_state_t st_d, st_q;

    sfa_op_e           op_sel;
    logic [DATA_W-1:0] add_a, add_b, sum_w, res_w;
    logic              add_cin, borrow_sense, keep_cf, write_req;
    logic              nib_co, half_c_msb, half_co, full_c_msb, full_co;
    sfa_flags_t        flags_w;

    assign op_sel = sfa_op_e'(op_code);

    sfa_operand_sel #(.DATA_W(DATA_W)) opsel_i (
        .op           (op_sel),
        .wide         (wide),
        .dst          (dst_opnd),
        .src          (src_opnd),
        .cf_in        (cf_in),
        .add_a        (add_a),
        .add_b        (add_b),
        .add_cin      (add_cin),
        .borrow_sense (borrow_sense),
        .keep_cf      (keep_cf),
        .write_req    (write_req)
    );

    sfa_adder_core #(.DATA_W(DATA_W), .NIB_W(NIB_W)) adder_i (
        .add_a      (add_a),
        .add_b      (add_b),
        .add_cin    (add_cin),
        .sum        (sum_w),
        .nib_co     (nib_co),
        .half_c_msb (half_c_msb),
        .half_co    (half_co),
        .full_c_msb (full_c_msb),
        .full_co    (full_co)
    );

    sfa_flag_gen #(.DATA_W(DATA_W), .PAR_W(PAR_W)) flags_i (
        .sum          (sum_w),
        .wide         (wide),
        .nib_co       (nib_co),
        .half_c_msb   (half_c_msb),
        .half_co      (half_co),
        .full_c_msb   (full_c_msb),
        .full_co      (full_co),
        .borrow_sense (borrow_sense),
        .keep_cf      (keep_cf),
        .cf_in        (cf_in),
        .res          (res_w),
        .flags        (flags_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        st_d.wr  = 1'b0;
        if (in_valid) begin
            st_d.wr  = write_req;
            st_d.res = res_w;
            st_d.flg = flags_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.vld;
    assign wr_en     = st_q.wr;
    assign result    = st_q.res;
    assign cf        = st_q.flg.cf;
    assign zf        = st_q.flg.zf;
    assign sf        = st_q.flg.sf;
    assign of        = st_q.flg.of;
    assign pf        = st_q.flg.pf;
    assign af        = st_q.flg.af;

endmodule

// File: rtl/sfa_checker.sv
module sfa_checker #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        op_code,
    input logic              wide,
    input logic [DATA_W-1:0] dst_opnd,
    input logic              cf_in,
    input logic              out_valid,
    input logic              wr_en,
    input logic [DATA_W-1:0] result,
    input logic              cf,
    input logic              zf,
    input logic              sf,
    input logic              of,
    input logic              pf,
    input logic              af
);
    localparam int HALF_W = DATA_W / 2;

    AST_STROBE_TO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && !wr_en && $stable(result) && $stable({cf, zf, sf, of, pf, af}))); // R1

    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 3'd2) |=> !wr_en); // R4

    AST_INCDEC_KEEP_CF: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && (op_code == 3'd4 || op_code == 3'd5)) |=> (cf == $past(cf_in))); // R5

    AST_NEG_CF_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 3'd3) |=>
            (cf == ($past(wide) ? ($past(dst_opnd) != '0) : ($past(dst_opnd[HALF_W-1:0]) != '0)))); // R6

    AST_ZF_IS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (zf == (result == '0))); // R7

    AST_SF_IS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (sf == ($past(wide) ? result[DATA_W-1] : result[HALF_W-1]))); // R7

    AST_PF_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (pf == ~^result[7:0])); // R9

    AST_BYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !wide) |=> (result[DATA_W-1:HALF_W] == '0)); // R11

endmodule

bind sub_flag_alu sfa_checker #(.DATA_W(DATA_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .op_code   (op_code),
    .wide      (wide),
    .dst_opnd  (dst_opnd),
    .cf_in     (cf_in),
    .out_valid (out_valid),
    .wr_en     (wr_en),
    .result    (result),
    .cf        (cf),
    .zf        (zf),
    .sf        (sf),
    .of        (of),
    .pf        (pf),
    .af        (af)
);

// File: tb/sub_flag_alu_tb_top.sv
module sub_flag_alu_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  op_code = 3'd0;
    logic        wide = 1'b0;
    logic [15:0] dst_opnd = '0;
    logic [15:0] src_opnd = '0;
    logic        cf_in = 1'b0;
    logic        out_valid, wr_en, cf, zf, sf, of, pf, af;
    logic [15:0] result;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    int       last_res;
    bit [5:0] last_flg;

    always #(CLK_PERIOD/2) clk = ~clk;

    sub_flag_alu dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_code(op_code),
        .wide(wide), .dst_opnd(dst_opnd), .src_opnd(src_opnd), .cf_in(cf_in),
        .out_valid(out_valid), .wr_en(wr_en), .result(result),
        .cf(cf), .zf(zf), .sf(sf), .of(of), .pf(pf), .af(af)
    );

    // Flags packed as {cf,zf,sf,of,pf,af}
    task automatic model(input int op, input bit w, input int d, input int s, input bit ci,
                         output int r, output bit ewr, output bit [5:0] ef);
        int n, m, a, b, sb, sa, sbv, cc, diff;
        bit fc, fz, fs, fo, fp, fa;
        n  = w ? 16 : 8;
        m  = (1 << n) - 1;
        a  = d & m;
        b  = s & m;
        sb = 1 << (n - 1);
        sa  = (a >= sb) ? a - (1 << n) : a;
        sbv = (b >= sb) ? b - (1 << n) : b;
        fc = 0; fa = 0; fo = 0; r = 0;
        case (op)
            3: begin r = (0 - a) & m; fc = (a != 0); fa = ((a & 15) != 0); fo = (a == sb); end
            4: begin r = (a + 1) & m; fc = ci; fa = ((a & 15) == 15); fo = (a == sb - 1); end
            5: begin r = (a - 1) & m; fc = ci; fa = ((a & 15) == 0); fo = (a == sb); end
            default: begin
                cc   = (op == 1) ? int'(ci) : 0;
                r    = (a - b - cc) & m;
                fc   = (a < b + cc);
                fa   = ((a & 15) < (b & 15) + cc);
                diff = sa - sbv - cc;
                fo   = (diff > sb - 1) || (diff < -sb);
            end
        endcase
        fz  = (r == 0);
        fs  = ((r & sb) != 0);
        fp  = ($countones(r & 255) % 2) == 0;
        ewr = (op == 0 || op == 1 || op == 3 || op == 4 || op == 5);
        ef  = {fc, fz, fs, fo, fp, fa};
    endtask

    // Called at a falling edge; drives one operation and checks it at the next falling edge.
    task automatic run_op(input int op, input bit w, input int d, input int s, input bit ci,
                          input string tag);
        int       er;
        bit       ewr;
        bit [5:0] ef;
        bit [5:0] got;
        in_valid = 1'b1;
        op_code  = op[2:0];
        wide     = w;
        dst_opnd = d[15:0];
        src_opnd = s[15:0];
        cf_in    = ci;
        model(op, w, d, s, ci, er, ewr, ef);
        @(negedge clk);
        got = {cf, zf, sf, of, pf, af};
        total++;
        if (!out_valid || int'(result) != er || wr_en != ewr || got != ef) begin
            bad++;
            $display("FAIL %s op=%0d w=%0d d=%h s=%h ci=%0d: got v=%0d res=%h wr=%0d flg=%b exp res=%h wr=%0d flg=%b",
                     tag, op, w, d, s, ci, out_valid, result, wr_en, got, er, ewr, ef);
        end
        last_res = er;
        last_flg = ef;
    endtask

    task automatic check(input bit cond, input string tag, input int act, input int exp);
        total++;
        if (!cond) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string op_tag(input int op);
        case (op)
            0: return "R2";
            1: return "R3";
            3: return "R6";
            4, 5: return "R5";
            default: return "R4";
        endcase
    endfunction

    int wv[12] = '{0, 1, 2, 'h000F, 'h0010, 'h00FF, 'h1234, 'h7FFE, 'h7FFF, 'h8000, 'h8001, 'hFFFF};

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check(out_valid == 0 && wr_en == 0 && result == 0 && {cf,zf,sf,of,pf,af} == 6'b0,
              "R12 reset", {out_valid, wr_en, cf, zf, sf, of, pf, af, result}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Directed corners
        run_op(0, 1, 'h7FFF, 'hFFFF, 0, "R8 7FFF-FFFF");
        check(result == 16'h8000 && of == 1, "R8 overflow", {of, result}, 'h18000);
        run_op(3, 1, 'h8000, 0, 0, "R6 neg 8000");
        check(result == 16'h8000 && of == 1 && cf == 1, "R6 neg min word", {cf, of, result}, 'h38000);
        run_op(3, 0, 'h0080, 0, 0, "R6 neg 80");
        run_op(3, 0, 'h0000, 0, 1, "R6 neg zero");
        check(cf == 0 && zf == 1, "R6 neg zero cf", {cf, zf}, 1);
        run_op(2, 1, 'h1234, 'h1234, 0, "R4 equal cmp");
        check(zf == 1 && wr_en == 0, "R4 cmp equal zf", {zf, wr_en}, 2);
        run_op(4, 0, 'h000F, 0, 1, "R10 inc nibble carry");
        check(af == 1 && cf == 1, "R10 inc af", {af, cf}, 3);
        run_op(0, 0, 'h0010, 'h0001, 0, "R10 sub nibble borrow");
        check(af == 1, "R10 sub af", af, 1);
        run_op(0, 0, 'h0003, 'h0000, 0, "R9 parity");
        check(pf == 1, "R9 pf even", pf, 1);
        run_op(0, 0, 'hAB05, 'hCD00, 0, "R11 dirty upper");
        check(result == 16'h0005 && cf == 0, "R11 upper ignored", {cf, result}, 'h5);
        run_op(6, 1, 'h0001, 'h0002, 0, "R4 code6");
        run_op(7, 0, 'h0001, 'h0002, 1, "R4 code7");
        run_op(5, 1, 'h8000, 0, 0, "R8 dec overflow");
        run_op(4, 1, 'h7FFF, 0, 1, "R5 inc keeps cf");

        // R1: idle cycles hold result and flags, ignore inputs
        in_valid = 1'b0;
        op_code  = 3'd3;
        dst_opnd = 16'h5555;
        src_opnd = 16'hAAAA;
        cf_in    = 1'b0;
        repeat (2) @(negedge clk);
        check(out_valid == 0 && wr_en == 0, "R1 idle valid", {out_valid, wr_en}, 0);
        check(int'(result) == last_res && {cf,zf,sf,of,pf,af} == last_flg, "R1 idle hold",
              {cf,zf,sf,of,pf,af,result}, {last_flg, last_res[15:0]});

        // R2 R7 R8 R10: exhaustive byte subtract
        for (int d = 0; d < 256; d++)
            for (int s = 0; s < 256; s++)
                run_op(0, 0, d | ((s * 7) << 8), s | (d << 8), 0, "R2 byte sweep");

        // R3: byte subtract with borrow
        for (int d = 0; d < 256; d++)
            for (int s = 0; s < 256; s += 3)
                for (int c = 0; c < 2; c++)
                    run_op(1, 0, d, s, c[0], "R3 byte sweep");

        // R4: byte compare
        for (int d = 0; d < 256; d++)
            for (int s = 0; s < 256; s += 7)
                run_op(2, 0, d, s, d[0], "R4 byte sweep");

        // R5 R6: unary ops over every byte, both carry inputs
        for (int op = 3; op <= 5; op++)
            for (int d = 0; d < 256; d++)
                for (int c = 0; c < 2; c++)
                    run_op(op, 0, d | 'hA500, 0, c[0], op_tag(op));

        // R11 word mode boundary sweep, every code
        for (int op = 0; op < 8; op++)
            for (int i = 0; i < 12; i++)
                for (int j = 0; j < 12; j++)
                    for (int c = 0; c < 2; c++)
                        run_op(op, 1, wv[i], wv[j], c[0], op_tag(op));

        in_valid = 1'b0;
        @(negedge clk);
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", WATCHDOG, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule